// File: doc/BRIEF.md
# Instruction-Set State Controller

This block keeps track of which instruction set a processor core runs: the 32-bit native set, the 16-bit compressed set, or a byte-coded stack-machine mode. It owns the current status word, a saved copy of that word for exception handling, and a link register. From them it derives the execution state that the fetch and decode logic use.

The decoder feeds it a small set of events. The first is a conditional branch that enters bytecode execution at an address held in a register. The second is exception entry, which carries a vector, a return address and a mode code. The third is exception return. The last is a direct write of the status word. Only one event takes effect per clock. After each accepted control transfer, the block presents the new program counter together with a one-cycle load strobe.

Fetch, decode, the datapath and the bytecode engine are outside this block. It only holds and sequences the architectural state that selects between them.

Top module: `isa_state_ctrl`

## Requirements
- R1: A synchronous reset (active-high `rst`) sets the status word to 32'h0000_00D3. This means flags 0, bytecode bit 0, compressed bit 0, both interrupt masks 1 and mode 5'b10011. Reset also clears the saved word, the link register and `pc_out`, and holds `pc_load` at 0.
- R2: `exec_state` decodes the bytecode bit (status bit 24) and the compressed bit (status bit 5). Both 0 gives native, 2'b00. Bytecode 0 with compressed 1 gives compressed, 2'b01. Bytecode 1 with compressed 0 gives bytecode, 2'b10.
- R3: A branch-to-bytecode request whose condition passes has the following effect one clock later: status bit 24 is 1, bit 5 is 0, `pc_out` equals the target value and `pc_load` is 1. All other status bits are unchanged.
- R4: A branch-to-bytecode request whose condition fails changes no status bit and no program counter, and `pc_load` stays 0.
- R5: The branch condition is evaluated against N (bit 31), Z (bit 30), C (bit 29) and V (bit 28) as follows. Codes 0 to 7 test, in pairs, Z set/clear, C set/clear, N set/clear and V set/clear. Code 8 passes when C=1 and Z=0, and code 9 is its inverse. Code 10 passes when N==V, and code 11 is its inverse. Code 12 passes when Z=0 and N==V, and code 13 is its inverse. Code 14 always passes and code 15 never passes.
- R6: Exception entry copies the status word into the saved word and puts `exc_link` into the link register. It clears bits 24 and 5, sets the IRQ mask (bit 7), loads bits 4:0 with `exc_mode` and keeps the flags. `pc_out` takes `exc_vector` and `pc_load` pulses.
- R7: Exception entry sets the FIQ mask (bit 6) when `exc_fast` is 1. Otherwise the FIQ mask keeps its previous value.
- R8: Exception return loads the status word from the saved word and sets `pc_out` to the link register minus 4 with a `pc_load` pulse. This puts the core back into bytecode state if it was interrupted there.
- R9: When several requests arrive in one cycle, only one takes effect. The order is exception entry, then exception return, then the branch request, then the status write. A branch request, even a failing one, blocks a status write in the same cycle.
- R10: A status write stores only bits 31:27, 24 and 7:0. Bits 26:25 and 23:8 always read 0. A status write does not change `pc_out` or `pc_load`.
- R11: A status word with bits 24 and 5 both set is reserved. `exec_state` reports native (2'b00) and `reserved_err` is 1 while it is held. In every other combination `reserved_err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| br_valid | input | 1 | Branch-to-bytecode request |
| br_cond | input | 4 | Condition code of the branch |
| br_target | input | 32 | Register value giving the bytecode start address |
| exc_valid | input | 1 | Exception entry request |
| exc_fast | input | 1 | Exception is a fast interrupt |
| exc_mode | input | 5 | Mode code for the exception |
| exc_vector | input | 32 | Handler address |
| exc_link | input | 32 | Return address to place in the link register |
| ret_valid | input | 1 | Exception return request |
| sw_valid | input | 1 | Status word write request |
| sw_data | input | 32 | Status word write data |
| exec_state | output | 2 | 00 native, 01 compressed, 10 bytecode |
| pc_out | output | 32 | Next program counter |
| pc_load | output | 1 | `pc_out` holds a new target this cycle |
| status_word | output | 32 | Current status word |
| saved_word | output | 32 | Saved status word |
| link_reg | output | 32 | Link register |
| reserved_err | output | 1 | Reserved bytecode+compressed combination held |

## Verification
Every piece of internal state appears directly on a port. A wrong flag, mask, state bit, saved copy or link value therefore shows up on `status_word`, `saved_word`, `link_reg` or `exec_state` at the first sampling point after the clock edge that produced it. A faulty condition decode or priority choice is visible one clock after the offending request, as an unexpected `pc_load` pulse or a status change where none should occur. A wrong saved copy or link value can also show up later, as a wrong `pc_out` or a failure to restore bytecode state on exception return. The bench therefore runs full entry and return round trips that start from each execution state.

// File: rtl/isa_state_ctrl.sv
module isa_state_ctrl #(
  parameter logic [4:0] RESET_MODE = 5'b10011,
  parameter int         RET_ADJ    = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        br_valid,
  input  logic [3:0]  br_cond,
  input  logic [31:0] br_target,
  input  logic        exc_valid,
  input  logic        exc_fast,
  input  logic [4:0]  exc_mode,
  input  logic [31:0] exc_vector,
  input  logic [31:0] exc_link,
  input  logic        ret_valid,
  input  logic        sw_valid,
  input  logic [31:0] sw_data,
  output logic [1:0]  exec_state,
  output logic [31:0] pc_out,
  output logic        pc_load,
  output logic [31:0] status_word,
  output logic [31:0] saved_word,
  output logic [31:0] link_reg,
  output logic        reserved_err
);

  localparam logic [31:0] KEEP_MASK = 32'hF900_00FF;
  localparam logic [31:0] RESET_PSR = {24'h0, 1'b1, 1'b1, 1'b0, RESET_MODE};
  localparam logic [31:0] ADJ       = 32'(RET_ADJ);

  logic [31:0] psr_q, spsr_q, lr_q, pc_q;
  logic        load_q;
  logic        cond_ok;

  wire fl_n = psr_q[31];
  wire fl_z = psr_q[30];
  wire fl_c = psr_q[29];
  wire fl_v = psr_q[28];
  wire bit_j = psr_q[24];
  wire bit_t = psr_q[5];

  always_comb begin
    unique case (br_cond[3:1])
      3'd0: cond_ok = fl_z;
      3'd1: cond_ok = fl_c;
      3'd2: cond_ok = fl_n;
      3'd3: cond_ok = fl_v;
      3'd4: cond_ok = fl_c & ~fl_z;
      3'd5: cond_ok = (fl_n == fl_v);
      3'd6: cond_ok = ~fl_z & (fl_n == fl_v);
      default: cond_ok = 1'b1;
    endcase
    if (br_cond[0]) cond_ok = ~cond_ok;
  end

  wire do_exc = exc_valid;
  wire do_ret = ret_valid & ~exc_valid;
  wire do_br  = br_valid & ~exc_valid & ~ret_valid & cond_ok;
  wire do_sw  = sw_valid & ~exc_valid & ~ret_valid & ~br_valid;

  always_ff @(posedge clk) begin
    if (rst) begin
      psr_q  <= RESET_PSR;
      spsr_q <= '0;
      lr_q   <= '0;
      pc_q   <= '0;
      load_q <= 1'b0;
    end else begin
      load_q <= 1'b0;
      if (do_exc) begin
        spsr_q <= psr_q;
        lr_q   <= exc_link;
        psr_q  <= {psr_q[31:27], 2'b00, 1'b0, 16'h0, 1'b1,
                   psr_q[6] | exc_fast, 1'b0, exc_mode};
        pc_q   <= exc_vector;
        load_q <= 1'b1;
      end else if (do_ret) begin
        psr_q  <= spsr_q;
        pc_q   <= lr_q - ADJ;
        load_q <= 1'b1;
      end else if (do_br) begin
        psr_q[24] <= 1'b1;
        psr_q[5]  <= 1'b0;
        pc_q      <= br_target;
        load_q    <= 1'b1;
      end else if (do_sw) begin
        psr_q <= sw_data & KEEP_MASK;
      end
    end
  end

  always_comb begin
    unique case ({bit_j, bit_t})
      2'b01:   exec_state = 2'b01;
      2'b10:   exec_state = 2'b10;
      default: exec_state = 2'b00;
    endcase
  end

  assign reserved_err = bit_j & bit_t;
  assign pc_out       = pc_q;
  assign pc_load      = load_q;
  assign status_word  = psr_q;
  assign saved_word   = spsr_q;
  assign link_reg     = lr_q;

  assert_reset_R1: assert property (@(posedge clk)
    rst |=> (psr_q == RESET_PSR && spsr_q == 32'h0 && lr_q == 32'h0 && !load_q));

  assert_state_R2: assert property (@(posedge clk) disable iff (rst)
    (exec_state == 2'b10) |-> (psr_q[24] && !psr_q[5]));

  assert_branch_R3: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !exc_valid && !ret_valid && cond_ok) |=>
      (psr_q[24] && !psr_q[5] && pc_q == $past(br_target) && load_q));

  assert_nobranch_R4: assert property (@(posedge clk) disable iff (rst)
    (br_valid && !exc_valid && !ret_valid && !cond_ok) |=>
      ($stable(psr_q) && $stable(pc_q) && !load_q));

  assert_entry_R6: assert property (@(posedge clk) disable iff (rst)
    exc_valid |=> (spsr_q == $past(psr_q) && lr_q == $past(exc_link) &&
                   !psr_q[24] && !psr_q[5] && psr_q[7] &&
                   psr_q[4:0] == $past(exc_mode) && pc_q == $past(exc_vector) && load_q));

  assert_fast_R7: assert property (@(posedge clk) disable iff (rst)
    (exc_valid && exc_fast) |=> psr_q[6]);

  assert_return_R8: assert property (@(posedge clk) disable iff (rst)
    (ret_valid && !exc_valid) |=> (psr_q == $past(spsr_q) && pc_q == $past(lr_q) - ADJ));

  assert_swquiet_R10: assert property (@(posedge clk) disable iff (rst)
    (sw_valid && !exc_valid && !ret_valid && !br_valid) |=> (!load_q && $stable(pc_q)));

  assert_reserved_R11: assert property (@(posedge clk) disable iff (rst)
    reserved_err |-> (exec_state == 2'b00));

endmodule

// File: tb/isa_state_ctrl_tb.sv
module isa_state_ctrl_tb_top;
  logic clk = 0;
  always #5 clk = ~clk;

  logic rst = 1;
  logic br_valid = 0, exc_valid = 0, exc_fast = 0, ret_valid = 0, sw_valid = 0;
  logic [3:0] br_cond = 0;
  logic [4:0] exc_mode = 0;
  logic [31:0] br_target = 0, exc_vector = 0, exc_link = 0, sw_data = 0;
  logic [1:0] exec_state;
  logic [31:0] pc_out, status_word, saved_word, link_reg;
  logic pc_load, reserved_err;

  isa_state_ctrl dut_i (.*);

  int checks = 0, fails = 0;
  bit finished = 0;
  logic [31:0] m_psr, m_spsr, m_lr, m_pc;
  logic m_load;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic bit cond_pass(logic [3:0] c, logic [31:0] p);
    bit n = p[31], z = p[30], cf = p[29], v = p[28];
    case (c)
      0: return z;        1: return !z;
      2: return cf;       3: return !cf;
      4: return n;        5: return !n;
      6: return v;        7: return !v;
      8: return cf && !z; 9: return !cf || z;
      10: return n == v;  11: return n != v;
      12: return !z && n == v; 13: return z || n != v;
      14: return 1;       default: return 0;
    endcase
  endfunction

  task automatic compare(string req);
    logic [1:0] es;
    if (m_psr[24] && !m_psr[5]) es = 2'b10;
    else if (!m_psr[24] && m_psr[5]) es = 2'b01;
    else es = 2'b00;
    chk(req, "status_word", status_word, m_psr);
    chk(req, "saved_word", saved_word, m_spsr);
    chk(req, "link_reg", link_reg, m_lr);
    chk(req, "pc_out", pc_out, m_pc);
    chk(req, "pc_load", {31'b0, pc_load}, {31'b0, m_load});
    chk(req, "exec_state", {30'b0, exec_state}, {30'b0, es});
    chk(req, "reserved_err", {31'b0, reserved_err}, {31'b0, m_psr[24] & m_psr[5]});
  endtask

  // One clock: drive at negedge, model the edge, compare at next negedge
  task automatic step(string req, bit bv, logic [3:0] bc, logic [31:0] bt,
                      bit ev, bit ef, logic [4:0] em, logic [31:0] evec, logic [31:0] el,
                      bit rv, bit sv, logic [31:0] sd);
    br_valid = bv; br_cond = bc; br_target = bt;
    exc_valid = ev; exc_fast = ef; exc_mode = em; exc_vector = evec; exc_link = el;
    ret_valid = rv; sw_valid = sv; sw_data = sd;
    m_load = 0;
    if (ev) begin
      m_spsr = m_psr; m_lr = el; m_pc = evec; m_load = 1;
      m_psr[24] = 0; m_psr[5] = 0; m_psr[7] = 1;
      if (ef) m_psr[6] = 1;
      m_psr[4:0] = em;
    end else if (rv) begin
      m_psr = m_spsr; m_pc = m_lr - 4; m_load = 1;
    end else if (bv) begin
      if (cond_pass(bc, m_psr)) begin
        m_psr[24] = 1; m_psr[5] = 0; m_pc = bt; m_load = 1;
      end
    end else if (sv) begin
      m_psr = sd;
      m_psr[26:25] = 0; m_psr[23:8] = 0;
    end
    @(posedge clk); @(negedge clk);
    br_valid = 0; exc_valid = 0; ret_valid = 0; sw_valid = 0;
    compare(req);
  endtask

  task automatic wr(string req, logic [31:0] d);
    step(req, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    m_psr = 32'h0000_00D3; m_spsr = 0; m_lr = 0; m_pc = 0; m_load = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    compare("R1");

    // R10 masking, R2 compressed state
    wr("R10", 32'hFFFF_FF1F & ~32'h0100_0000);
    wr("R2", 32'h0000_0030);

    // R5 / R3 / R4: every code against every flag pattern
    for (int f = 0; f < 16; f++) begin
      for (int c = 0; c < 16; c++) begin
        wr("R5", {f[3:0], 28'h000_0010});
        step(cond_pass(c[3:0], {f[3:0], 28'h0}) ? "R3" : "R4",
             1, c[3:0], 32'h1000_0000 + 32'(f * 64 + c * 4), 0, 0, 0, 0, 0, 0, 0, 0);
      end
    end

    // R3 from compressed state clears T
    wr("R2", 32'h4000_0030);
    step("R3", 1, 4'd0, 32'h0000_8001, 0, 0, 0, 0, 0, 0, 0, 0);

    // R6/R8 round trip from bytecode state
    step("R6", 0, 0, 0, 1, 0, 5'b10010, 32'h0000_0018, 32'h0000_8010, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    // R7 fast entry, then non-fast keeps F clear
    wr("R7", 32'hA000_0010);
    step("R7", 0, 0, 0, 1, 1, 5'b10001, 32'h0000_001C, 32'h0000_2004, 0, 0, 0);
    step("R8", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    step("R7", 0, 0, 0, 1, 0, 5'b10010, 32'h0000_0018, 32'h0000_3000, 0, 0, 0);

    // R9 priority
    wr("R9", 32'h0000_0010);
    step("R9", 1, 4'd14, 32'h5555_0000, 1, 0, 5'b10111, 32'h10, 32'h0000_7000, 1, 1, 32'hF000_0030);
    step("R9", 1, 4'd14, 32'h6666_0000, 0, 0, 0, 0, 0, 1, 1, 32'hF000_0030);
    step("R9", 1, 4'd14, 32'h7777_0000, 0, 0, 0, 0, 0, 0, 1, 32'hF000_0030);
    step("R9", 1, 4'd15, 32'h8888_0000, 0, 0, 0, 0, 0, 0, 1, 32'hF000_0030);

    // R11 reserved combination, then cleared
    wr("R11", 32'h0100_0030);
    step("R11", 0, 0, 0, 1, 0, 5'b10011, 32'h8, 32'h44, 0, 0, 0);
    step("R11", 0, 0, 0, 0, 0, 0, 0, 0, 1, 0, 0);
    wr("R11", 32'h0100_0010);

    // R1 reset mid-run
    rst = 1;
    @(posedge clk); @(negedge clk);
    rst = 0;
    m_psr = 32'h0000_00D3; m_spsr = 0; m_lr = 0; m_pc = 0; m_load = 0;
    compare("R1");

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule